// File: doc/BRIEF.md
# Per-Source Trigger-Mode Interrupt Controller

This block collects 32 interrupt inputs and turns them into two processor request lines and one wake line. Each source has its own trigger mode: disabled, one of three edge modes, or one of two level modes. The mode is a 3-bit code held in three separate configuration planes, so bit `i` of each plane belongs to source `i`. Edge events are held in two latch registers, one for rising and one for falling edges, until software clears them. A level source is active only while its input sits at the active level.

Each source is qualified by a mask bit and steered to one of the two request lines by a routing bit. A separate wake-enable plane lets an active source drive the wake output whatever its mask. Every control plane is changed through a set address and a clear address: a 1 in the write data acts on the matching bit, and a 0 leaves it alone. Each plane also has its own read address. The pending word of each request line can be read, as can the synchronised input levels.

Addresses are 6 bits wide. Bits [5:2] pick the register: 0 mode plane 0 (least significant mode bit), 1 mode plane 1, 2 mode plane 2, 3 mask, 4 routing, 5 wake enable, 6 rising latch, 7 falling latch, 8 line-0 pending, 9 line-1 pending, 10 synchronised inputs. Bits [1:0] pick the operation: 0 read, 1 set, 2 clear, 3 reserved.

Top module: `ic_trig_ctrl`

## Requirements
- R1: After reset, the mode planes, mask, wake enable and both edge latches read 0 and the routing plane reads all ones. req0_o, req1_o and wake_o are low.
- R2: A write with operation 1 ORs the write data into the selected control plane (registers 0 to 5). A write with operation 2 clears the bits that are 1 in the write data. Bits written as 0 keep their value. The plane reads back on operation 0 of the same register in the cycle after the write.
- R3: The mode code is {plane2,plane1,plane0}. Code 001 latches rising edges, 010 latches falling edges and 011 latches both. A latch bit reads 1 from the third rising clock edge after the input change. It does not read 1 before that edge.
- R4: Code 101 makes a source active while its input is high, and code 110 while its input is low. This shows in the pending word from the second rising clock edge after the input change. The source stops being active when the level goes away, with no clearing needed.
- R5: Codes 000, 100 and 111 never make a source active and never set either edge latch.
- R6: An edge latch bit stays set until a write with operation 2 to register 6 (rising) or register 7 (falling) clears it. The bit stays set if the mask or mode changes in the meantime. Writes with operation 1 to registers 6 to 10, and any write with operation 3, change nothing.
- R7: A source appears in a pending word only while its mask bit is 1. Its edge latch still records events while the mask bit is 0.
- R8: An active, unmasked source with routing bit 1 appears in the line-0 pending word (register 8). With routing bit 0 it appears in the line-1 pending word (register 9). No source appears in both.
- R9: req0_o is high exactly when the line-0 pending word is non-zero, and req1_o exactly when the line-1 pending word is non-zero.
- R10: wake_o is high when any active source has its wake-enable bit set, regardless of its mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw interrupt inputs, one per source |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Register select [5:2] and operation [1:0] |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Combinational read data for the addressed register |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
The assertions assume that the inputs are low while reset is applied. Otherwise the first synchronised sample would register as a rising edge that no model expects. The bench holds irq_in at zero through reset. After each input change it waits until the synchroniser and edge detector have settled before it writes registers. A mode change therefore never coincides with an edge in flight, and the latch contents stay predictable from the mode in force when the input moved. Random steps mix input flips, set and clear writes to every plane and latch clears, including the unused mode codes. Directed steps pin down the exact cycle when latches and level activity first appear.

// File: rtl/ictc_pkg.sv
package ictc_pkg;

    // register select field, bus_addr[5:2]
    typedef enum logic [3:0] {
        SEL_MODE0  = 4'd0,
        SEL_MODE1  = 4'd1,
        SEL_MODE2  = 4'd2,
        SEL_MASK   = 4'd3,
        SEL_ROUTE  = 4'd4,
        SEL_WAKE   = 4'd5,
        SEL_RISE   = 4'd6,
        SEL_FALL   = 4'd7,
        SEL_PEND0  = 4'd8,
        SEL_PEND1  = 4'd9,
        SEL_SYNCIN = 4'd10
    } reg_sel_e;

    // operation field, bus_addr[1:0]
    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSV  = 2'd3
    } reg_op_e;

    // trigger mode codes {plane2, plane1, plane0}
    localparam logic [2:0] MODE_OFF   = 3'b000;
    localparam logic [2:0] MODE_RISE  = 3'b001;
    localparam logic [2:0] MODE_FALL  = 3'b010;
    localparam logic [2:0] MODE_BOTH  = 3'b011;
    localparam logic [2:0] MODE_HIGH  = 3'b101;
    localparam logic [2:0] MODE_LOW   = 3'b110;

    localparam int N_CTL_PLANES = 6;

endpackage

// File: rtl/ic_sync.sv
module ic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ic_ctrl_regs.sv
module ic_ctrl_regs
    import ictc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  reg_op_e      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode0,
    output logic [W-1:0] mode1,
    output logic [W-1:0] mode2,
    output logic [W-1:0] mask,
    output logic [W-1:0] route,
    output logic [W-1:0] wake_en
);
    logic [W-1:0] plane_q [N_CTL_PLANES];

    for (genvar p = 0; p < N_CTL_PLANES; p++) begin : g_plane
        // routing plane resets to all ones, the rest to zero
        localparam logic [W-1:0] RST_VAL = (p == int'(SEL_ROUTE)) ? '1 : '0;
        logic hit;
        assign hit = wr && (sel == reg_sel_e'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                plane_q[p] <= RST_VAL;
            end else if (hit) begin
                unique case (op)
                    OP_SET:  plane_q[p] <= plane_q[p] | wdata;
                    OP_CLR:  plane_q[p] <= plane_q[p] & ~wdata;
                    default: plane_q[p] <= plane_q[p];
                endcase
            end
        end
    end

    assign mode0   = plane_q[int'(SEL_MODE0)];
    assign mode1   = plane_q[int'(SEL_MODE1)];
    assign mode2   = plane_q[int'(SEL_MODE2)];
    assign mask    = plane_q[int'(SEL_MASK)];
    assign route   = plane_q[int'(SEL_ROUTE)];
    assign wake_en = plane_q[int'(SEL_WAKE)];
endmodule

// File: rtl/ic_edge_detect.sv
module ic_edge_detect
    import ictc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] mode0,
    input  logic [W-1:0] mode1,
    input  logic [W-1:0] mode2,
    input  logic [W-1:0] rise_clr,
    input  logic [W-1:0] fall_clr,
    output logic [W-1:0] rise_lat,
    output logic [W-1:0] fall_lat,
    output logic [W-1:0] lvl_act
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise_en;
    logic [W-1:0] fall_en;
    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_in;
    end

    assign rise_ev = lvl_in & ~prev_q;
    assign fall_ev = ~lvl_in & prev_q;

    for (genvar i = 0; i < W; i++) begin : g_src
        logic [2:0] code;
        assign code = {mode2[i], mode1[i], mode0[i]};

        always_comb begin
            rise_en[i] = 1'b0;
            fall_en[i] = 1'b0;
            lvl_act[i] = 1'b0;
            case (code)
                MODE_RISE: rise_en[i] = 1'b1;
                MODE_FALL: fall_en[i] = 1'b1;
                MODE_BOTH: begin
                    rise_en[i] = 1'b1;
                    fall_en[i] = 1'b1;
                end
                MODE_HIGH: lvl_act[i] = lvl_in[i];
                MODE_LOW:  lvl_act[i] = ~lvl_in[i];
                default:   ;
            endcase
        end
    end

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_lat <= '0;
            fall_lat <= '0;
        end else begin
            rise_lat <= (rise_lat & ~rise_clr) | (rise_ev & rise_en);
            fall_lat <= (fall_lat & ~fall_clr) | (fall_ev & fall_en);
        end
    end
endmodule

// File: rtl/ic_trig_ctrl.sv
module ic_trig_ctrl
    import ictc_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    reg_sel_e         sel;
    reg_op_e          op;
    logic [N_SRC-1:0] sync_lvl;
    logic [N_SRC-1:0] mode0, mode1, mode2;
    logic [N_SRC-1:0] mask_q, route_q, wake_q;
    logic [N_SRC-1:0] rise_lat, fall_lat, lvl_act;
    logic [N_SRC-1:0] rise_clr, fall_clr;
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] pend0, pend1;

    assign sel = reg_sel_e'(bus_addr[ADDR_W-1:2]);
    assign op  = reg_op_e'(bus_addr[1:0]);

    ic_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (sync_lvl)
    );

    ic_ctrl_regs #(.W(N_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .op      (op),
        .wdata   (bus_wdata),
        .mode0   (mode0),
        .mode1   (mode1),
        .mode2   (mode2),
        .mask    (mask_q),
        .route   (route_q),
        .wake_en (wake_q)
    );

    assign rise_clr = (bus_wr && sel == SEL_RISE && op == OP_CLR) ? bus_wdata : '0;
    assign fall_clr = (bus_wr && sel == SEL_FALL && op == OP_CLR) ? bus_wdata : '0;

    ic_edge_detect #(.W(N_SRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (sync_lvl),
        .mode0    (mode0),
        .mode1    (mode1),
        .mode2    (mode2),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .rise_lat (rise_lat),
        .fall_lat (fall_lat),
        .lvl_act  (lvl_act)
    );

    assign active = lvl_act | rise_lat | fall_lat;
    assign pend0  = active & mask_q & route_q;
    assign pend1  = active & mask_q & ~route_q;

    assign req0_o = |pend0;
    assign req1_o = |pend1;
    assign wake_o = |(active & wake_q);

    always_comb begin
        case (sel)
            SEL_MODE0:  bus_rdata = mode0;
            SEL_MODE1:  bus_rdata = mode1;
            SEL_MODE2:  bus_rdata = mode2;
            SEL_MASK:   bus_rdata = mask_q;
            SEL_ROUTE:  bus_rdata = route_q;
            SEL_WAKE:   bus_rdata = wake_q;
            SEL_RISE:   bus_rdata = rise_lat;
            SEL_FALL:   bus_rdata = fall_lat;
            SEL_PEND0:  bus_rdata = pend0;
            SEL_PEND1:  bus_rdata = pend1;
            SEL_SYNCIN: bus_rdata = sync_lvl;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ic_trig_ctrl_chk.sv
module ic_trig_ctrl_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req0_o,
    input logic         req1_o,
    input logic         wake_o,
    input logic [W-1:0] pend0,
    input logic [W-1:0] pend1,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] route_q,
    input logic [W-1:0] wake_q,
    input logic [W-1:0] mode0,
    input logic [W-1:0] mode2,
    input logic [W-1:0] rise_lat,
    input logic [W-1:0] rise_clr
);
    // R7
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend0 | pend1) & ~mask_q) == '0);

    // R8
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend0 & pend1) == '0);

    // R8
    route_line1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req1_o |-> (~route_q & mask_q) != '0);

    // R9
    req0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req0_o |-> (route_q & mask_q) != '0);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise_lat) & ~$past(rise_clr)) & ~rise_lat) == '0);

    // R5
    no_spur_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rise_lat & ~$past(rise_lat) & ~($past(mode0) & ~$past(mode2))) == '0);

    // R10
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> wake_q != '0);
endmodule

bind ic_trig_ctrl ic_trig_ctrl_chk #(.W(N_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req0_o   (req0_o),
    .req1_o   (req1_o),
    .wake_o   (wake_o),
    .pend0    (pend0),
    .pend1    (pend1),
    .mask_q   (mask_q),
    .route_q  (route_q),
    .wake_q   (wake_q),
    .mode0    (mode0),
    .mode2    (mode2),
    .rise_lat (rise_lat),
    .rise_clr (rise_clr)
);

// File: tb/sim_ic_trig_ctrl.sv
module sim_ic_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req0_o, req1_o, wake_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [31:0] m_c0 = '0, m_c1 = '0, m_c2 = '0;
    logic [31:0] m_mask = '0, m_route = '1, m_wake = '0;
    logic [31:0] m_rise = '0, m_fall = '0, m_in = '0;

    ic_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] f_active();
        logic [31:0] lvl;
        lvl = m_c2 & ((m_c0 & ~m_c1 & m_in) | (m_c1 & ~m_c0 & ~m_in));
        return lvl | m_rise | m_fall;
    endfunction

    function automatic logic [31:0] f_pend0();
        return f_active() & m_mask & m_route;
    endfunction

    function automatic logic [31:0] f_pend1();
        return f_active() & m_mask & ~m_route;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {sel, op}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        if (op == 2'd1) begin
            case (sel)
                4'd0: m_c0 |= d;    4'd1: m_c1 |= d;    4'd2: m_c2 |= d;
                4'd3: m_mask |= d;  4'd4: m_route |= d; 4'd5: m_wake |= d;
                default: ;
            endcase
        end else if (op == 2'd2) begin
            case (sel)
                4'd0: m_c0 &= ~d;    4'd1: m_c1 &= ~d;    4'd2: m_c2 &= ~d;
                4'd3: m_mask &= ~d;  4'd4: m_route &= ~d; 4'd5: m_wake &= ~d;
                4'd6: m_rise &= ~d;  4'd7: m_fall &= ~d;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [3:0] sel, output logic [31:0] v);
        @(negedge clk);
        bus_addr = {sel, 2'd0};
        #1 v = bus_rdata;
    endtask

    task automatic set_mode(input int b, input logic [2:0] code);
        wr(4'd0, code[0] ? 2'd1 : 2'd2, 32'd1 << b);
        wr(4'd1, code[1] ? 2'd1 : 2'd2, 32'd1 << b);
        wr(4'd2, code[2] ? 2'd1 : 2'd2, 32'd1 << b);
    endtask

    task automatic set_inputs(input logic [31:0] v);
        logic [31:0] rise_en, fall_en;
        rise_en = ~m_c2 & m_c0;
        fall_en = ~m_c2 & m_c1;
        m_rise |= (v & ~m_in) & rise_en;
        m_fall |= (~v & m_in) & fall_en;
        @(negedge clk);
        irq_in = v;
        repeat (4) @(negedge clk);
        m_in = v;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(4'd8, v); check({tag, " R8 pend0"}, v, f_pend0());
        rd(4'd9, v); check({tag, " R8 pend1"}, v, f_pend1());
        rd(4'd6, v); check({tag, " R3 rise"}, v, m_rise);
        rd(4'd7, v); check({tag, " R3 fall"}, v, m_fall);
        check({tag, " R9 req0"}, {31'd0, req0_o}, {31'd0, f_pend0() != 0});
        check({tag, " R9 req1"}, {31'd0, req1_o}, {31'd0, f_pend1() != 0});
        check({tag, " R10 wake"}, {31'd0, wake_o}, {31'd0, (f_active() & m_wake) != 0});
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); check("R1 mode0", v, 32'd0);
        rd(4'd2, v); check("R1 mode2", v, 32'd0);
        rd(4'd3, v); check("R1 mask", v, 32'd0);
        rd(4'd4, v); check("R1 route", v, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R1 wake", v, 32'd0);
        rd(4'd6, v); check("R1 rise", v, 32'd0);
        check("R1 outs", {29'd0, req0_o, req1_o, wake_o}, 32'd0);

        // R2 set/clear semantics
        wr(4'd3, 2'd1, 32'hA5A5_A5A5);
        wr(4'd3, 2'd2, 32'h0F0F_0F0F);
        wr(4'd3, 2'd1, 32'h0);
        rd(4'd3, v); check("R2 mask set/clr", v, 32'hA0A0_A0A0);
        wr(4'd3, 2'd2, 32'hFFFF_FFFF);
        wr(4'd5, 2'd3, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R6 op3 ignored", v, 32'd0);

        // R3 rising-edge latch timing on source 0
        set_mode(0, 3'b001);
        wr(4'd3, 2'd1, 32'h1);
        bus_addr = {4'd6, 2'd0};
        @(negedge clk); irq_in = 32'h1;
        @(negedge clk); #1 check("R3 latch after edge1", bus_rdata, 32'd0);
        @(negedge clk); #1 check("R3 latch after edge2", bus_rdata, 32'd0);
        @(negedge clk); #1 check("R3 latch after edge3", bus_rdata, 32'd1);
        check("R9 req0 edge", {31'd0, req0_o}, 32'd1);
        m_in = 32'h1; m_rise = 32'h1;
        repeat (2) @(negedge clk);

        // R6 persistence across mask and mode changes
        wr(4'd3, 2'd2, 32'h1);
        set_mode(0, 3'b000);
        rd(4'd6, v); check("R6 latch held", v, 32'h1);
        check("R7 req0 masked", {31'd0, req0_o}, 32'd0);
        wr(4'd6, 2'd1, 32'h2);
        rd(4'd6, v); check("R6 set on latch ignored", v, 32'h1);
        wr(4'd3, 2'd1, 32'h1);
        check("R6 req0 back", {31'd0, req0_o}, 32'd1);
        wr(4'd6, 2'd2, 32'h1);
        check_all("R6 cleared");

        // R4 level-high timing on source 1, routed to line 1
        set_mode(1, 3'b101);
        wr(4'd3, 2'd1, 32'h2);
        wr(4'd4, 2'd2, 32'h2);
        bus_addr = {4'd9, 2'd0};
        @(negedge clk); irq_in = 32'h3;
        @(negedge clk); #1 check("R4 level after edge1", bus_rdata, 32'd0);
        @(negedge clk); #1 check("R4 level after edge2", bus_rdata, 32'h2);
        m_in = 32'h3;
        check("R8 req1", {31'd0, req1_o}, 32'd1);
        set_inputs(32'h1);
        check_all("R4 level released");

        // R4 level-low, R5 unused codes, R7 masked latch, R10 wake
        set_mode(2, 3'b110);
        set_mode(3, 3'b100);
        set_mode(4, 3'b111);
        set_mode(5, 3'b010);
        wr(4'd3, 2'd1, 32'h1C);
        check_all("R4 low active");
        set_inputs(32'h3D);
        set_inputs(32'h01);
        check_all("R5 R7 unused codes and masked falling");
        wr(4'd5, 2'd1, 32'h20);
        check_all("R10 wake unmasked");
        wr(4'd7, 2'd2, 32'hFFFF_FFFF);
        wr(4'd5, 2'd2, 32'hFFFF_FFFF);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int k;
            k = $urandom % 4;
            if (k == 0) set_inputs(m_in ^ ($urandom & $urandom));
            else if (k == 1) wr(4'($urandom % 6), ($urandom % 2) ? 2'd1 : 2'd2, $urandom);
            else if (k == 2) wr(($urandom % 2) ? 4'd6 : 4'd7, 2'd2, $urandom);
            else wr(4'($urandom % 11), 2'd3, $urandom);
            check_all("R2 R3 R4 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule